// File: doc/BRIEF.md
# Serial Stream Word Aligner

This block recovers word boundaries on a lane whose bits arrive in the right order but with an unknown frame phase. Each 40 MHz frame carries one raw word of `LANE_W` bits (16 at the 640 Mb/s rate; 8 or 32 for the slower or faster lane settings). The receiving front end tunes its bit sampling, but it does not align words. Word alignment is the job of this block.

The transmit half sits beside the data source. When a bunch-crossing-zero sync pulse arrives, it replaces three payload frames with a fixed marker: a word of zeros, then a word of ones, then a word of zeros. The receive half keeps the last two raw words and examines every bit offset of that window, one frame at a time. When the full marker appears at one offset, the receiver locks to that offset and freezes it. It then delivers realigned words with valid and lock flags and reports the offset. If a later marker turns up at another offset, the receiver drops lock, pulses a misalignment flag and waits for the next marker.

Top module: `swa_aligner`

## Requirements
- R1: In a frame where `tx_sync` is high and no marker is in progress, `tx_word` becomes all zeros after that clock edge. It becomes all ones after the next edge and all zeros after the edge after that.
- R2: When neither `tx_sync` nor a marker is active, `tx_word` equals the `tx_payload` value presented one frame earlier.
- R3: A `tx_sync` pulse that arrives while a marker is being sent is ignored. The marker neither restarts nor grows longer, and the payload resumes on the fourth frame.
- R4: After reset and before any marker, `rx_locked`, `rx_valid` and `rx_misalign` are 0, and `rx_word` and `rx_offset` are 0. Whenever the block is unlocked, `rx_word` reads 0 and `rx_valid` reads 0.
- R5: Raw words are read MSB first, so bit `LANE_W-1` of a word is the earliest bit. If the stream lags the frame clock by k bits (0 <= k < `LANE_W`), a marker locks the block with `rx_offset` = k. Suppose the first marker word is captured at edge n. Then `rx_locked` is still 0 after edge n+3 and is 1 after edge n+4.
- R6: While locked, `rx_valid` is 1. After each edge, `rx_word` equals the transmitted word of the frame before the one just captured.
- R7: A marker seen again at the locked offset keeps `rx_locked` at 1, leaves `rx_offset` unchanged and does not raise `rx_misalign`.
- R8: A marker seen at a different offset while locked clears `rx_locked` and sets `rx_offset` to 0. It raises `rx_misalign` for exactly one frame, in the same frame where lock is dropped. Only the next marker locks the block again, this time at the new offset.
- R9: Synchronous reset (`rst` high at an edge) clears lock, offset, misalignment and output word, including while the block is locked.
- R10: A zeros word followed by a ones word, without a closing zeros word, never locks the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_payload | input | LANE_W | Payload word to transmit |
| tx_sync | input | 1 | Bunch-crossing-zero sync pulse |
| tx_word | output | LANE_W | Word sent to the lane (payload or marker) |
| rx_raw | input | LANE_W | Raw received word, bit-aligned only |
| rx_word | output | LANE_W | Realigned word, zero while unlocked |
| rx_valid | output | 1 | Realigned word is valid |
| rx_locked | output | 1 | Word boundary is locked |
| rx_offset | output | $clog2(LANE_W) | Locked bit offset |
| rx_misalign | output | 1 | One-frame pulse when a marker shows up at a new offset |

## Verification
Two decisions can be driven by the same marker hit: acquiring lock and dropping it for misalignment. The bench locks the block at one bit shift, moves the stream to another shift and sends a new marker. In the frame where the new marker completes, it checks that the block drops lock and pulses misalignment instead of jumping to the new offset. It then checks that a second marker relocks at the new shift. On the transmit side, the bench holds the sync pulse across the marker so that marker start and sync overlap. It then confirms that the marker keeps its three-frame shape.

// File: rtl/swa_pkg.sv
package swa_pkg;

  // Default lane word width: 16 bits per frame.
  localparam int unsigned DEF_LANE_W = 16;

  // Transmit marker phases.
  typedef enum logic [1:0] {
    MK_IDLE = 2'd0,
    MK_ONES = 2'd1,
    MK_TAIL = 2'd2
  } mk_phase_t;

endpackage

// File: rtl/swa_marker_gen.sv
// Transmit helper: replaces three payload frames with zeros/ones/zeros
// after a sync pulse.
module swa_marker_gen #(
  parameter int unsigned LANE_W = swa_pkg::DEF_LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LANE_W-1:0] payload,
  input  logic              sync,
  output logic [LANE_W-1:0] word,
  output logic              busy,
  output logic              in_ones
);
  import swa_pkg::*;

  mk_phase_t         phase_q;
  logic [LANE_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= MK_IDLE;
      word_q  <= '0;
    end else begin
      unique case (phase_q)
        MK_IDLE: begin
          if (sync) begin
            word_q  <= '0;
            phase_q <= MK_ONES;
          end else begin
            word_q  <= payload;
          end
        end
        MK_ONES: begin
          word_q  <= '1;
          phase_q <= MK_TAIL;
        end
        MK_TAIL: begin
          word_q  <= '0;
          phase_q <= MK_IDLE;
        end
        default: begin
          word_q  <= '0;
          phase_q <= MK_IDLE;
        end
      endcase
    end
  end

  assign word    = word_q;
  assign busy    = (phase_q != MK_IDLE);
  assign in_ones = (phase_q == MK_ONES);

endmodule

// File: rtl/swa_window.sv
// Keeps the previous and current raw words and exposes every
// word-wide candidate inside that window.
module swa_window #(
  parameter int unsigned LANE_W = swa_pkg::DEF_LANE_W
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [LANE_W-1:0]              raw,
  output logic [2*LANE_W-1:0]            win,
  output logic [LANE_W-1:0][LANE_W-1:0]  cand
);
  logic [LANE_W-1:0] prev_q;
  logic [LANE_W-1:0] cur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      cur_q  <= '0;
    end else begin
      prev_q <= cur_q;
      cur_q  <= raw;
    end
  end

  assign win = {prev_q, cur_q};

  // Candidate k starts k bits after the first bit of the older word.
  for (genvar k = 0; k < LANE_W; k++) begin : g_cand
    assign cand[k] = win[2*LANE_W-1-k -: LANE_W];
  end

endmodule

// File: rtl/swa_scan.sv
// Per-offset marker tracking: zeros, then ones, then zeros at the same offset.
module swa_scan #(
  parameter  int unsigned LANE_W = swa_pkg::DEF_LANE_W,
  localparam int unsigned OFF_W  = $clog2(LANE_W)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [LANE_W-1:0][LANE_W-1:0] cand,
  output logic [LANE_W-1:0]             hit,
  output logic                          any_hit,
  output logic [OFF_W-1:0]              hit_idx
);
  logic [LANE_W-1:0] seen_zero_q;
  logic [LANE_W-1:0] seen_ones_q;

  for (genvar k = 0; k < LANE_W; k++) begin : g_track
    logic is_zero;
    logic is_ones;
    assign is_zero = (cand[k] == '0);
    assign is_ones = (cand[k] == '1);

    always_ff @(posedge clk) begin
      if (rst) begin
        seen_zero_q[k] <= 1'b0;
        seen_ones_q[k] <= 1'b0;
      end else begin
        seen_zero_q[k] <= is_zero;
        seen_ones_q[k] <= seen_zero_q[k] && is_ones;
      end
    end

    assign hit[k] = seen_ones_q[k] && is_zero;
  end

  // Lowest offset wins when more than one offset matches.
  function automatic logic [OFF_W-1:0] lowest_set(input logic [LANE_W-1:0] v);
    logic [OFF_W-1:0] r;
    r = '0;
    for (int i = LANE_W - 1; i >= 0; i--) begin
      if (v[i]) r = OFF_W'(i);
    end
    return r;
  endfunction

  assign any_hit = |hit;
  assign hit_idx = lowest_set(hit);

endmodule

// File: rtl/swa_lock.sv
// Lock control: acquire on a hit, hold the offset, drop on a hit elsewhere.
module swa_lock #(
  parameter  int unsigned LANE_W = swa_pkg::DEF_LANE_W,
  localparam int unsigned OFF_W  = $clog2(LANE_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             any_hit,
  input  logic [OFF_W-1:0] hit_idx,
  output logic             locked,
  output logic [OFF_W-1:0] offset,
  output logic             misalign
);
  logic             locked_q;
  logic [OFF_W-1:0] offset_q;
  logic             mis_q;
  logic             acquire;
  logic             moved;

  assign acquire = !locked_q && any_hit;
  assign moved   = locked_q && any_hit && (hit_idx != offset_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q <= 1'b0;
      offset_q <= '0;
      mis_q    <= 1'b0;
    end else begin
      mis_q <= moved;
      if (acquire) begin
        locked_q <= 1'b1;
        offset_q <= hit_idx;
      end else if (moved) begin
        locked_q <= 1'b0;
        offset_q <= '0;
      end
    end
  end

  assign locked   = locked_q;
  assign offset   = offset_q;
  assign misalign = mis_q;

endmodule

// File: rtl/swa_aligner.sv
// Serial stream word aligner: marker insertion and boundary recovery.
module swa_aligner #(
  parameter  int unsigned LANE_W = swa_pkg::DEF_LANE_W,
  localparam int unsigned OFF_W  = $clog2(LANE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LANE_W-1:0] tx_payload,
  input  logic              tx_sync,
  output logic [LANE_W-1:0] tx_word,
  input  logic [LANE_W-1:0] rx_raw,
  output logic [LANE_W-1:0] rx_word,
  output logic              rx_valid,
  output logic              rx_locked,
  output logic [OFF_W-1:0]  rx_offset,
  output logic              rx_misalign
);
  // Named internal events (observed by the checker).
  logic                          tx_busy;
  logic                          tx_ones;
  logic [2*LANE_W-1:0]           win;
  logic [LANE_W-1:0][LANE_W-1:0] cand;
  logic [LANE_W-1:0]             hit;
  logic                          any_hit;
  logic [OFF_W-1:0]              hit_idx;

  swa_marker_gen #(.LANE_W(LANE_W)) u_mk (
    .clk     (clk),
    .rst     (rst),
    .payload (tx_payload),
    .sync    (tx_sync),
    .word    (tx_word),
    .busy    (tx_busy),
    .in_ones (tx_ones)
  );

  swa_window #(.LANE_W(LANE_W)) u_win (
    .clk  (clk),
    .rst  (rst),
    .raw  (rx_raw),
    .win  (win),
    .cand (cand)
  );

  swa_scan #(.LANE_W(LANE_W)) u_scan (
    .clk     (clk),
    .rst     (rst),
    .cand    (cand),
    .hit     (hit),
    .any_hit (any_hit),
    .hit_idx (hit_idx)
  );

  swa_lock #(.LANE_W(LANE_W)) u_lock (
    .clk      (clk),
    .rst      (rst),
    .any_hit  (any_hit),
    .hit_idx  (hit_idx),
    .locked   (rx_locked),
    .offset   (rx_offset),
    .misalign (rx_misalign)
  );

  // Word that starts 'off' bits into the older half of the window.
  function automatic logic [LANE_W-1:0] take_slice(
    input logic [2*LANE_W-1:0] w,
    input logic [OFF_W-1:0]    off
  );
    logic [2*LANE_W-1:0] sh;
    sh = w << off;
    return sh[2*LANE_W-1 -: LANE_W];
  endfunction

  assign rx_word  = rx_locked ? take_slice(win, rx_offset) : '0;
  assign rx_valid = rx_locked;

endmodule

// File: rtl/swa_aligner_chk.sv
// Property checker bound to the aligner top.
module swa_aligner_chk #(
  parameter  int unsigned LANE_W = swa_pkg::DEF_LANE_W,
  localparam int unsigned OFF_W  = $clog2(LANE_W)
) (
  input logic              clk,
  input logic              rst,
  input logic [LANE_W-1:0] tx_payload,
  input logic              tx_sync,
  input logic [LANE_W-1:0] tx_word,
  input logic              tx_busy,
  input logic              tx_ones,
  input logic [LANE_W-1:0] rx_word,
  input logic              rx_valid,
  input logic              rx_locked,
  input logic [OFF_W-1:0]  rx_offset,
  input logic              rx_misalign,
  input logic              any_hit,
  input logic [OFF_W-1:0]  hit_idx
);

  // R1
  mark_start_chk: assert property (@(posedge clk) disable iff (rst)
    tx_sync && !tx_busy |=> tx_word == '0);

  // R1
  mark_ones_chk: assert property (@(posedge clk) disable iff (rst)
    tx_ones |=> tx_word == '1);

  // R2
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_sync && !tx_busy |=> tx_word == $past(tx_payload));

  // R3
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    tx_busy && !tx_ones |=> !tx_busy && tx_word == '0);

  // R4
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_locked |-> rx_word == '0 && !rx_valid);

  // R5
  lock_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_locked) |-> $past(any_hit) && rx_offset == $past(hit_idx));

  // R7
  offset_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rx_locked && $past(rx_locked) |-> $stable(rx_offset));

  // R8
  mis_drop_chk: assert property (@(posedge clk) disable iff (rst)
    rx_misalign |-> !rx_locked && $past(rx_locked) && $past(any_hit)
                    && $past(hit_idx) != $past(rx_offset));

  // R8
  mis_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_misalign |=> !rx_misalign);

  // R9
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> !rx_locked && rx_offset == '0 && !rx_misalign);

endmodule

bind swa_aligner swa_aligner_chk #(.LANE_W(LANE_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tx_payload  (tx_payload),
  .tx_sync     (tx_sync),
  .tx_word     (tx_word),
  .tx_busy     (tx_busy),
  .tx_ones     (tx_ones),
  .rx_word     (rx_word),
  .rx_valid    (rx_valid),
  .rx_locked   (rx_locked),
  .rx_offset   (rx_offset),
  .rx_misalign (rx_misalign),
  .any_hit     (any_hit),
  .hit_idx     (hit_idx)
);

// File: tb/swa_aligner_bench.sv
`timescale 1ns/1ps
module swa_aligner_bench;
  localparam int W  = 16;
  localparam int OW = $clog2(W);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  tx_payload = '0;
  logic          tx_sync = 1'b0;
  logic [W-1:0]  rx_raw = '0;
  logic [W-1:0]  tx_word;
  logic [W-1:0]  rx_word;
  logic          rx_valid;
  logic          rx_locked;
  logic [OW-1:0] rx_offset;
  logic          rx_misalign;

  always #2.5 clk = ~clk;

  swa_aligner #(.LANE_W(W)) u_swa_aligner (
    .clk         (clk),
    .rst         (rst),
    .tx_payload  (tx_payload),
    .tx_sync     (tx_sync),
    .tx_word     (tx_word),
    .rx_raw      (rx_raw),
    .rx_word     (rx_word),
    .rx_valid    (rx_valid),
    .rx_locked   (rx_locked),
    .rx_offset   (rx_offset),
    .rx_misalign (rx_misalign)
  );

  int           n_chk = 0;
  int           n_bad = 0;
  int           shift = 0;
  logic [W-1:0] prev_w = '0;
  logic [W-1:0] exp_word = '0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pl(input int i);
    return {8'h5A, 8'(i * 7 + 3)};
  endfunction

  // One frame: lane word w (shifted by 'shift' bits), tx inputs, then sample.
  task automatic step(input logic [W-1:0] w, input logic [W-1:0] pay,
                      input logic sync);
    logic [2*W-1:0] cat;
    cat        = {prev_w, w} >> shift;
    rx_raw     = cat[W-1:0];
    exp_word   = prev_w;
    prev_w     = w;
    tx_payload = pay;
    tx_sync    = sync;
    @(posedge clk);
    #1;
  endtask

  task automatic send_marker();
    step('0, '0, 1'b0);
    step('1, '0, 1'b0);
    step('0, '0, 1'b0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(pl(0), '0, 1'b0);
    step(pl(1), '0, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R4", "locked after reset", 32'(rx_locked), 0);
    check("R4", "valid after reset", 32'(rx_valid), 0);
    check("R4", "word after reset", 32'(rx_word), 0);
    check("R4", "offset after reset", 32'(rx_offset), 0);
    check("R4", "misalign after reset", 32'(rx_misalign), 0);
  endtask

  task automatic t_tx();
    do_reset();
    step(pl(2), 16'h1234, 1'b0);
    check("R2", "payload pass", 32'(tx_word), 32'h1234);
    step(pl(3), 16'hBEEF, 1'b1);
    check("R1", "marker zeros", 32'(tx_word), 0);
    step(pl(4), 16'h7777, 1'b1);
    check("R3", "marker ones under sync", 32'(tx_word), 32'hFFFF);
    step(pl(5), 16'h2222, 1'b1);
    check("R3", "marker tail under sync", 32'(tx_word), 0);
    step(pl(6), 16'hC0DE, 1'b0);
    check("R3", "payload resumes", 32'(tx_word), 32'hC0DE);
    step(pl(7), 16'h0F0F, 1'b0);
    check("R2", "payload pass again", 32'(tx_word), 32'h0F0F);
  endtask

  // Marker at the current shift; checks lock timing, offset, data.
  task automatic acquire(input int k);
    for (int i = 0; i < 5; i++) begin
      step(pl(10 + i), '0, 1'b0);
      check("R4", "unlocked before marker", 32'(rx_locked), 0);
    end
    send_marker();
    step(pl(20), '0, 1'b0);
    check("R5", "no lock at edge n+3", 32'(rx_locked), 0);
    check("R4", "word zero while unlocked", 32'(rx_word), 0);
    step(pl(21), '0, 1'b0);
    check("R5", "lock at edge n+4", 32'(rx_locked), 1);
    check("R5", "offset", 32'(rx_offset), 32'(k));
    check("R6", "valid", 32'(rx_valid), 1);
    check("R6", "first aligned word", 32'(rx_word), 32'(exp_word));
  endtask

  task automatic t_lock(input int k);
    do_reset();
    shift = k;
    acquire(k);
    for (int i = 0; i < 4; i++) begin
      step(pl(30 + i), '0, 1'b0);
      check("R6", "aligned word", 32'(rx_word), 32'(exp_word));
    end
  endtask

  task automatic t_same(input int k);
    do_reset();
    shift = k;
    acquire(k);
    send_marker();
    for (int i = 0; i < 3; i++) begin
      step(pl(40 + i), '0, 1'b0);
      check("R7", "still locked", 32'(rx_locked), 1);
      check("R7", "no misalign", 32'(rx_misalign), 0);
      check("R7", "offset held", 32'(rx_offset), 32'(k));
      check("R6", "word incl. marker tail", 32'(rx_word), 32'(exp_word));
    end
  endtask

  task automatic t_partial();
    do_reset();
    shift = 6;
    for (int i = 0; i < 3; i++) step(pl(50 + i), '0, 1'b0);
    step('0, '0, 1'b0);
    step('1, '0, 1'b0);
    step(pl(55), '0, 1'b0);
    for (int i = 0; i < 5; i++) begin
      step(pl(60 + i), '0, 1'b0);
      check("R10", "broken marker no lock", 32'(rx_locked), 0);
    end
  endtask

  task automatic t_misalign();
    do_reset();
    shift = 3;
    acquire(3);
    shift = 9;
    for (int i = 0; i < 3; i++) step(pl(70 + i), '0, 1'b0);
    send_marker();
    step(pl(75), '0, 1'b0);
    check("R8", "lock held until marker completes", 32'(rx_locked), 1);
    check("R8", "no early misalign", 32'(rx_misalign), 0);
    step(pl(76), '0, 1'b0);
    check("R8", "lock dropped", 32'(rx_locked), 0);
    check("R8", "misalign pulse", 32'(rx_misalign), 1);
    check("R8", "offset cleared", 32'(rx_offset), 0);
    check("R8", "word zero", 32'(rx_word), 0);
    check("R8", "valid low", 32'(rx_valid), 0);
    step(pl(77), '0, 1'b0);
    check("R8", "misalign one frame", 32'(rx_misalign), 0);
    check("R8", "no relock without marker", 32'(rx_locked), 0);
    acquire(9);
  endtask

  task automatic t_reset_locked();
    do_reset();
    shift = 12;
    acquire(12);
    rst = 1'b1;
    step(pl(80), '0, 1'b0);
    rst = 1'b0;
    check("R9", "reset clears lock", 32'(rx_locked), 0);
    check("R9", "reset clears offset", 32'(rx_offset), 0);
    check("R9", "reset clears word", 32'(rx_word), 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_tx();
    t_lock(0);
    t_lock(5);
    t_lock(15);
    t_same(7);
    t_partial();
    t_misalign();
    t_reset_locked();
    summary();
    $finish;
  end

endmodule